// File: doc/BRIEF.md
# Pad Hit Capture with Time-Bin Stamping

This block sits behind the discriminators of a 64-pad readout front end. Every pad arrives as a one-bit hit flag, already compared against one threshold shared by all channels. The block groups clock cycles into fixed time bins of `TICK_CYCLES` clocks each; with the intended clock, one bin lasts 100 ns. A free-running bin counter numbers the bins. Any hit seen in any cycle of a bin is ORed into that bin's 64-bit pattern. A per-channel enable word removes disabled channels when the bin closes.

A mode pin selects between two ways of reporting. In free-running mode, each bin that ends with at least one enabled hit becomes a record. In gated mode, closed bins move down a delay line of `DEPTH` stages. A trigger pulse copies one stage, chosen by a latency input, into the output queue, so a trigger that arrives late still picks out the right bin. Records carry the bin number and the hit pattern. They wait in a small queue and leave on a valid/ready stream. A record stays on the outputs, unchanged, for as long as `rec_ready_i` is low. It leaves on a clock edge where valid and ready are both high. If a record must be queued while the queue is full and nothing leaves in that cycle, the record is dropped and a sticky overflow flag is raised.

Top module: `padhit_capture`

## Requirements
- R1: After reset, `rec_valid_o` and `ovf_o` are low, and the first bin after reset is numbered 0.
- R2: A bin spans `TICK_CYCLES` consecutive clocks, the first bin starting on the first clock edge after reset. Hits present at any edge of the bin are ORed into the bin's pattern. Successive bins are numbered 0, 1, 2, …, and the number wraps to 0 after 2^`TS_W`-1.
- R3: A pad whose bit in `chan_en_i` is 0 at the bin's last edge contributes nothing to that bin's pattern.
- R4: With `mode_i`=1 (free-running), a bin whose enabled pattern is non-zero produces a record with that bin's number and pattern. The record is valid right after the bin's last edge. An all-zero bin produces no record, and `trig_i` has no effect.
- R5: With `mode_i`=0 (gated), closed bins produce no record. A `trig_i` high at an edge belonging to bin n queues a record of bin n-1-`lat_i`, even when its pattern is all zero. The record is valid right after that edge.
- R6: A trigger on the last edge of a bin uses the delay line as it was before that bin is shifted in.
- R7: Records leave in the order they were queued. While `rec_valid_o` is high and `rec_ready_i` is low, the record on the outputs does not change.
- R8: A record to be queued while `FIFO_DEPTH` records are waiting, with no record leaving in that cycle, is dropped. `ovf_o` then goes high and stays high until reset.
- R9: When the queue is full and a record leaves in the same cycle that a new one arrives, the new record is accepted and `ovf_o` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NCH | Discriminated hit flag of each pad |
| chan_en_i | input | NCH | Per-channel enable, 1 keeps the channel |
| mode_i | input | 1 | 1 = free-running, 0 = trigger-gated |
| trig_i | input | 1 | Trigger strobe, one per clock when high |
| lat_i | input | LAT_W | Delay-line stage read out by a trigger |
| rec_valid_o | output | 1 | Output record present |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_ts_o | output | TS_W | Bin number of the record |
| rec_hits_o | output | NCH | Hit pattern of the record |
| ovf_o | output | 1 | Sticky record-dropped flag |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a trigger arrives on the last clock of a bin, the same edge that shifts a new bin into the delay line. The bench places the strobe on that edge, expects the older bin, and compares both number and pattern. In the second pair, a record leaves the full queue in the same cycle a new bin closes. The bench opens `rec_ready_i` for exactly that one edge, then confirms that `ovf_o` stayed low and that the new record comes out last in the drained sequence.

// File: rtl/padhit_pkg.sv
package padhit_pkg;
  typedef enum logic {
    MODE_GATED = 1'b0,
    MODE_FREE  = 1'b1
  } capture_mode_e;
endpackage

// File: rtl/padhit_binner.sv
module padhit_binner #(
  parameter int NCH         = 64,
  parameter int TS_W        = 24,
  parameter int TICK_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  pad_i,
  input  logic [NCH-1:0]  chan_en_i,
  output logic            bin_end_o,
  output logic [TS_W-1:0] bin_ts_o,
  output logic [NCH-1:0]  bin_hits_o
);
  localparam int DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [DIV_W-1:0] div_q;
  logic [NCH-1:0]   acc_q;
  logic [TS_W-1:0]  ts_q;

  assign bin_end_o  = (div_q == DIV_W'(TICK_CYCLES - 1));
  assign bin_hits_o = (acc_q | pad_i) & chan_en_i;
  assign bin_ts_o   = ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      acc_q <= '0;
      ts_q  <= '0;
    end else if (bin_end_o) begin
      div_q <= '0;
      acc_q <= '0;
      ts_q  <= ts_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      acc_q <= acc_q | pad_i;
    end
  end
endmodule

// File: rtl/padhit_pipe.sv
module padhit_pipe #(
  parameter int NCH   = 64,
  parameter int TS_W  = 24,
  parameter int DEPTH = 8,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [NCH-1:0]   hits_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [TS_W-1:0]  ts_o,
  output logic [NCH-1:0]   hits_o
);
  logic [TS_W-1:0] ts_q   [DEPTH];
  logic [NCH-1:0]  hits_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ts_q[g]   <= '0;
        hits_q[g] <= '0;
      end else if (shift_i) begin
        if (g == 0) begin
          ts_q[g]   <= ts_i;
          hits_q[g] <= hits_i;
        end else begin
          ts_q[g]   <= ts_q[g-1];
          hits_q[g] <= hits_q[g-1];
        end
      end
    end
  end

  always_comb begin
    int sel;
    sel = int'(lat_i);
    if (sel > DEPTH - 1) sel = DEPTH - 1;
    ts_o   = ts_q[sel];
    hits_o = hits_q[sel];
  end
endmodule

// File: rtl/padhit_fifo.sv
module padhit_fifo #(
  parameter int W     = 88,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o,
  output logic         ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, pop, accept;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o && ready_i;
  assign accept  = push_i && (!full || pop);
  assign dout_o  = mem[rd_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (accept) wr_q <= bump(wr_q);
      if (pop)    rd_q <= bump(rd_q);
      if (accept && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !accept) cnt_q <= cnt_q - 1'b1;
      if (push_i && !accept)   ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/padhit_capture.sv
module padhit_capture #(
  parameter int NCH         = 64,
  parameter int TS_W        = 24,
  parameter int TICK_CYCLES = 4,
  parameter int DEPTH       = 8,
  parameter int FIFO_DEPTH  = 4,
  localparam int LAT_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pad_i,
  input  logic [NCH-1:0]   chan_en_i,
  input  logic             mode_i,
  input  logic             trig_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [TS_W-1:0]  rec_ts_o,
  output logic [NCH-1:0]   rec_hits_o,
  output logic             ovf_o
);
  import padhit_pkg::*;

  localparam int REC_W = TS_W + NCH;

  logic            bin_end;
  logic [TS_W-1:0] bin_ts, sel_ts;
  logic [NCH-1:0]  bin_hits, sel_hits;
  logic            push;
  logic [REC_W-1:0] push_rec, head_rec;

  padhit_binner #(.NCH(NCH), .TS_W(TS_W), .TICK_CYCLES(TICK_CYCLES)) u_binner (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .chan_en_i(chan_en_i),
    .bin_end_o(bin_end), .bin_ts_o(bin_ts), .bin_hits_o(bin_hits)
  );

  padhit_pipe #(.NCH(NCH), .TS_W(TS_W), .DEPTH(DEPTH), .LAT_W(LAT_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .shift_i(bin_end), .ts_i(bin_ts), .hits_i(bin_hits),
    .lat_i(lat_i), .ts_o(sel_ts), .hits_o(sel_hits)
  );

  always_comb begin
    if (capture_mode_e'(mode_i) == MODE_FREE) begin
      push     = bin_end && (bin_hits != '0);
      push_rec = {bin_ts, bin_hits};
    end else begin
      push     = trig_i;
      push_rec = {sel_ts, sel_hits};
    end
  end

  padhit_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(push_rec),
    .ready_i(rec_ready_i), .valid_o(rec_valid_o), .dout_o(head_rec), .ovf_o(ovf_o)
  );

  assign rec_ts_o   = head_rec[REC_W-1:NCH];
  assign rec_hits_o = head_rec[NCH-1:0];
endmodule

// File: rtl/padhit_capture_chk.sv
module padhit_capture_chk #(
  parameter int NCH  = 64,
  parameter int TS_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_i,
  input logic            trig_i,
  input logic            rec_valid_o,
  input logic            rec_ready_i,
  input logic [TS_W-1:0] rec_ts_o,
  input logic [NCH-1:0]  rec_hits_o,
  input logic            ovf_o
);
  // R1: nothing pending and no overflow on the first edge after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rec_valid_o && !ovf_o));

  // R7: a stalled record holds its contents
  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_ts_o) && $stable(rec_hits_o)));

  // R8: overflow is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R8: overflow only rises while the output was stalled
  a_r8_ovf_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(rec_valid_o && !rec_ready_i));

  // R5: a gated trigger into an empty queue yields a record next cycle
  a_r5_trig_yields_record: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == padhit_pkg::MODE_GATED && trig_i && !rec_valid_o) |=> rec_valid_o);

  // R4: a fresh record in free-running mode is never empty
  a_r4_free_record_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && $past(mode_i) && !$past(rec_valid_o) && rec_valid_o) |-> (rec_hits_o != '0));
endmodule

bind padhit_capture padhit_capture_chk #(.NCH(NCH), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_i(trig_i),
  .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
  .rec_ts_o(rec_ts_o), .rec_hits_o(rec_hits_o), .ovf_o(ovf_o)
);

// File: tb/sim_padhit_capture.sv
`timescale 1ns/1ps
module sim_padhit_capture;
  localparam int NCH = 64;
  localparam int TSW = 4;
  localparam int LW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pad_i = '0;
  logic [NCH-1:0] chan_en_i = '1;
  logic           mode_i = 1'b1;
  logic           trig_i = 1'b0;
  logic [LW-1:0]  lat_i = '0;
  logic           rec_ready_i = 1'b1;
  logic           rec_valid_o, ovf_o;
  logic [TSW-1:0] rec_ts_o;
  logic [NCH-1:0] rec_hits_o;

  int nvec = 0, nerr = 0, edge_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) edge_n <= rst_n ? edge_n + 1 : 0;

  padhit_capture #(.NCH(NCH), .TS_W(TSW), .TICK_CYCLES(4), .DEPTH(8), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .chan_en_i(chan_en_i), .mode_i(mode_i),
    .trig_i(trig_i), .lat_i(lat_i), .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i),
    .rec_ts_o(rec_ts_o), .rec_hits_o(rec_hits_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic [63:0] pa;
    logic [63:0] pb;
    logic        trg;
    logic        ev;
    logic [63:0] eh;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 64'h8000_0000_0000_0001},
    '{64'h0, 64'h0, 1'b1, 1'b0, 64'h0},
    '{64'h0000_0000_0000_0020, 64'h0, 1'b0, 1'b0, 64'h0},
    '{64'h0000_00F0_0000_0021, 64'h0000_0F00_0000_0000, 1'b0, 1'b1, 64'h0000_0FF0_0000_0001},
    '{64'hDEAD_BEEF_0000_0000, 64'hDEAD_BEEF_0000_0000, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0000},
    '{64'h0, 64'h0000_0000_0000_0040, 1'b0, 1'b1, 64'h0000_0000_0000_0040}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_edge(input int n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode, input logic rdy);
    @(negedge clk);
    rst_n = 1'b0;
    pad_i = '0; trig_i = 1'b0; lat_i = '0; chan_en_i = '1;
    mode_i = mode; rec_ready_i = rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hit_at(input int e, input logic [63:0] p);
    wait_edge(e - 1); pad_i = p;
    wait_edge(e);     pad_i = '0;
  endtask

  task automatic trig_at(input int e, input logic [LW-1:0] l);
    wait_edge(e - 1); trig_i = 1'b1; lat_i = l;
    wait_edge(e);     trig_i = 1'b0;
  endtask

  task automatic expect_rec(input string tag, input logic [TSW-1:0] ts, input logic [63:0] h);
    chk({tag, " valid"}, 128'(rec_valid_o), 128'(1'b1));
    chk({tag, " ts"},    128'(rec_ts_o),    128'(ts));
    chk({tag, " hits"},  128'(rec_hits_o),  128'(h));
  endtask

  initial begin
    do_reset(1'b1, 1'b1);
    // R1: idle right after reset
    chk("R1 valid after reset", 128'(rec_valid_o), 128'(1'b0));
    chk("R1 ovf after reset",   128'(ovf_o),       128'(1'b0));

    // Table: free-running mode, channel 5 disabled (R2 R3 R4)
    chan_en_i = ~(64'h1 << 5);
    for (int i = 0; i < 6; i++) begin
      wait_edge(4*i);     pad_i = VEC[i].pa;
      wait_edge(4*i + 1); pad_i = '0; trig_i = VEC[i].trg;
      wait_edge(4*i + 2); trig_i = 1'b0; pad_i = VEC[i].pb;
      chk($sformatf("R4 no early record v%0d", i), 128'(rec_valid_o), 128'(1'b0));
      wait_edge(4*i + 3); pad_i = '0;
      wait_edge(4*i + 4);
      chk($sformatf("R4 R3 valid v%0d", i), 128'(rec_valid_o), 128'(VEC[i].ev));
      if (VEC[i].ev) begin
        chk($sformatf("R2 ts v%0d", i),   128'(rec_ts_o),   128'(i));
        chk($sformatf("R2 hits v%0d", i), 128'(rec_hits_o), 128'(VEC[i].eh));
      end
    end

    // R2: bin number wrap
    hit_at(61, 64'h1);
    wait_edge(64); expect_rec("R2 bin15", 4'd15, 64'h1);
    hit_at(65, 64'h2);
    wait_edge(68); expect_rec("R2 wrap", 4'd0, 64'h2);

    // Gated mode (R5 R6)
    do_reset(1'b0, 1'b1);
    hit_at(9, 64'hA5);
    hit_at(13, 64'h3C00);
    wait_edge(16);
    chk("R5 no bin records when gated", 128'(rec_valid_o), 128'(1'b0));
    wait_edge(18);
    trig_at(19, 3'd1);
    expect_rec("R5 lat1", 4'd2, 64'hA5);
    trig_at(22, 3'd2);
    expect_rec("R5 lat2", 4'd2, 64'hA5);
    trig_at(28, 3'd2);
    expect_rec("R6 trig on bin edge", 4'd3, 64'h3C00);
    trig_at(30, 3'd5);
    expect_rec("R5 empty bin record", 4'd1, 64'h0);

    // Overflow (R7 R8)
    do_reset(1'b1, 1'b0);
    for (int b = 0; b < 5; b++) hit_at(4*b + 1, 64'(b + 1));
    wait_edge(20);
    chk("R8 ovf set", 128'(ovf_o), 128'(1'b1));
    expect_rec("R7 head held", 4'd0, 64'h1);
    rec_ready_i = 1'b1;
    wait_edge(21); expect_rec("R7 order 1", 4'd1, 64'h2);
    wait_edge(22); expect_rec("R7 order 2", 4'd2, 64'h3);
    wait_edge(23); expect_rec("R7 order 3", 4'd3, 64'h4);
    wait_edge(24);
    chk("R8 dropped record", 128'(rec_valid_o), 128'(1'b0));
    chk("R8 ovf sticky",     128'(ovf_o),       128'(1'b1));

    // Push and pop on a full queue (R9)
    do_reset(1'b1, 1'b0);
    for (int b = 0; b < 4; b++) hit_at(4*b + 1, 64'(b + 1));
    hit_at(21, 64'h6);
    wait_edge(23); rec_ready_i = 1'b1;
    wait_edge(24); rec_ready_i = 1'b0;
    chk("R9 no ovf", 128'(ovf_o), 128'(1'b0));
    expect_rec("R9 head", 4'd1, 64'h2);
    rec_ready_i = 1'b1;
    wait_edge(25); expect_rec("R9 next", 4'd2, 64'h3);
    wait_edge(26); expect_rec("R9 next2", 4'd3, 64'h4);
    wait_edge(27); expect_rec("R9 kept", 4'd5, 64'h6);
    wait_edge(28);
    chk("R9 drained", 128'(rec_valid_o), 128'(1'b0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule